// File: doc/BRIEF.md
# Write-Allocate Decision Unit

This unit sits beside an L1 data cache and rules on every memory write that misses the cache and could be cached. For each such write it decides whether the cache should allocate. An allocation means the line is fetched with a burst, the write data is merged into it, and the line is kept as modified. The cache arrays, the burst engine and the merge logic live elsewhere. This unit only gives the verdict.

Four independent learning paths can grant an allocation:
- **Fill page:** the write's page equals the page of the most recent line fill.
- **Sector:** the write hits a valid sector whose addressed line is invalid.
- **Learned page:** the write's page equals a page learned from an external write that returned the cacheable indication. This path only counts while the detection-enable bit is set.
- **Limit:** the address lies below a programmable limit.

The result of these four paths is then cut by exclusions. A fixed hole at 640 KB to 1 MB always blocks. The 15–16 MB window blocks the limit path unless its enable bit is set. Three global cache-disable inputs also block.

Software programs a 9-bit control word through a write port. Page learning is fed by fill events and by cacheable-external-write events. The learned page is forgotten on translation changes, cache invalidation or a flush request. Each request is answered exactly one cycle later with a valid strobe, an allocate bit and a 4-bit vector naming the paths that fired.

Top module: `wa_decider`

## Requirements
- R1: After reset the following are all cleared, so a write with no sector hit receives no allocate: the control word, both page registers, and the decision outputs.
- R2: `decValid` is high in the cycle after `reqValid` and low otherwise. While `decValid` is low, `decAllocate` and `decSource` are zero.
- R3: Every `fillValid` stores `fillPage`. A later request whose address bits 31:12 equal the stored page sets `decSource[0]`.
- R4: A request with `sectorHit` high sets `decSource[1]`.
- R5: Every `kenWrValid` stores `kenWrPage`. A later request to that page sets `decSource[2]` only while control bit 8 (detection enable) is 1.
- R6: Any of `tlbChange`, `cacheInval` or `flushReq` forgets the learned page. This takes priority over a capture in the same cycle.
- R7: Control bits 7:1 form a field L. The limit path sets `decSource[3]` when the address is below L × 4 MB. When L = 0 this path never fires.
- R8: When L ≥ 4, a limit-path grant for an address in 00F0_0000h–00FF_FFFFh needs control bit 0 to be 1. Other paths are not affected by bit 0.
- R9: Requests to 000A_0000h–000F_FFFFh never allocate, whatever paths match.
- R10: No allocate is given while `cacheDisable`, `pageCacheDisable` or `cacheInhibit` is high.
- R11: `decAllocate` equals the OR of `decSource`. Several source bits may be set together.
- R12: A request is judged on register contents from before any fill, capture, invalidation or control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Pending write miss to be judged |
| reqAddr | input | 32 | Byte address of the write |
| sectorHit | input | 1 | Valid sector matched but addressed line invalid |
| pageCacheDisable | input | 1 | Per-request page cache disable |
| cacheDisable | input | 1 | Global cache disable |
| cacheInhibit | input | 1 | Test-mode cache inhibit |
| fillValid | input | 1 | A line fill happened |
| fillPage | input | 20 | Page number of the filled line |
| kenWrValid | input | 1 | External write returned cacheable indication |
| kenWrPage | input | 20 | Page number of that write |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 9 | New control word |
| tlbChange | input | 1 | Translation entry changed |
| cacheInval | input | 1 | Cache invalidate or write-back-invalidate |
| flushReq | input | 1 | Flush request recognised |
| decValid | output | 1 | Decision strobe |
| decAllocate | output | 1 | Allocate verdict |
| decSource | output | 4 | Paths that fired: 0 fill page, 1 sector, 2 learned page, 3 limit |

## Verification
A wrong page register or a stale valid bit shows up at the ports on the very next request to that page. It appears as a missing or extra bit in `decSource`, one cycle after the request. A miscoded limit field or a misplaced window boundary shows up only at addresses next to the boundary. For that reason, every limit value is swept with addresses just below and at its boundary, and with addresses on both sides of the fixed hole and the 15–16 MB window. Invalidation and same-cycle ordering faults are caught by a request issued right after the event.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int SRC_FILL   = 0;
  localparam int SRC_SECTOR = 1;
  localparam int SRC_KEN    = 2;
  localparam int SRC_LIMIT  = 3;
  localparam int SRC_W      = 4;

  typedef struct packed {
    logic loadCfg;
    logic loadFill;
    logic loadKen;
    logic clrKen;
  } waStrobes_t;

  typedef struct packed {
    logic fillHit;
    logic kenHit;
    logic belowLimit;
    logic inHole;
    logic inMidWin;
    logic limitGe16;
    logic detectEn;
    logic midWinEn;
  } waMatch_t;
endpackage

// File: rtl/wa_datapath.sv
module wa_datapath
  import wa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int LIM_W    = 7,
  parameter int LIM_LSB  = 22,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h000F_FFFF,
  parameter logic [ADDR_W-1:0] MID_LO  = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] MID_HI  = 32'h00FF_FFFF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  waStrobes_t                 stb,
  input  logic [LIM_W+1:0]           cfgWrData,
  input  logic [ADDR_W-PAGE_LSB-1:0] fillPage,
  input  logic [ADDR_W-PAGE_LSB-1:0] kenWrPage,
  input  logic [ADDR_W-1:0]          reqAddr,
  output waMatch_t                   match
);
  localparam int CFG_W  = LIM_W + 2;
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int HI_W   = ADDR_W - LIM_LSB;
  localparam logic [ADDR_W-1:0] MID_END = MID_HI + 1'b1;
  localparam logic [LIM_W-1:0] GE16_FIELD = LIM_W'(MID_END >> LIM_LSB);

  logic [CFG_W-1:0]  cfgQ;
  logic [PAGE_W-1:0] fillPageQ, kenPageQ;
  logic              fillVQ, kenVQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      fillPageQ <= '0;
      fillVQ    <= 1'b0;
      kenPageQ  <= '0;
      kenVQ     <= 1'b0;
    end else begin
      if (stb.loadCfg) cfgQ <= cfgWrData;
      if (stb.loadFill) begin
        fillPageQ <= fillPage;
        fillVQ    <= 1'b1;
      end
      if (stb.clrKen) begin
        kenVQ <= 1'b0;
      end else if (stb.loadKen) begin
        kenPageQ <= kenWrPage;
        kenVQ    <= 1'b1;
      end
    end
  end

  logic [LIM_W-1:0]  limField;
  logic [PAGE_W-1:0] reqPage;
  assign limField = cfgQ[LIM_W:1];
  assign reqPage  = reqAddr[ADDR_W-1:PAGE_LSB];

  always_comb begin
    match.fillHit    = fillVQ && (reqPage == fillPageQ);
    match.kenHit     = kenVQ && (reqPage == kenPageQ);
    match.belowLimit = reqAddr[ADDR_W-1:LIM_LSB] < {{(HI_W-LIM_W){1'b0}}, limField};
    match.inHole     = (reqAddr >= HOLE_LO) && (reqAddr <= HOLE_HI);
    match.inMidWin   = (reqAddr >= MID_LO) && (reqAddr <= MID_HI);
    match.limitGe16  = limField >= GE16_FIELD;
    match.detectEn   = cfgQ[CFG_W-1];
    match.midWinEn   = cfgQ[0];
  end
endmodule

// File: rtl/wa_control.sv
module wa_control
  import wa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             sectorHit,
  input  logic             pageCacheDisable,
  input  logic             cacheDisable,
  input  logic             cacheInhibit,
  input  logic             fillValid,
  input  logic             kenWrValid,
  input  logic             cfgWrEn,
  input  logic             tlbChange,
  input  logic             cacheInval,
  input  logic             flushReq,
  input  waMatch_t         match,
  output waStrobes_t       stb,
  output logic             decValid,
  output logic             decAllocate,
  output logic [SRC_W-1:0] decSource
);
  always_comb begin
    stb.loadCfg  = cfgWrEn;
    stb.loadFill = fillValid;
    stb.loadKen  = kenWrValid;
    stb.clrKen   = tlbChange | cacheInval | flushReq;
  end

  logic             blocked;
  logic [SRC_W-1:0] rawSrc, grantSrc;

  always_comb begin
    blocked = cacheDisable | pageCacheDisable | cacheInhibit | match.inHole;
    rawSrc             = '0;
    rawSrc[SRC_FILL]   = match.fillHit;
    rawSrc[SRC_SECTOR] = sectorHit;
    rawSrc[SRC_KEN]    = match.kenHit & match.detectEn;
    rawSrc[SRC_LIMIT]  = match.belowLimit &
                         !(match.limitGe16 & match.inMidWin & !match.midWinEn);
    grantSrc = blocked ? '0 : rawSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid    <= 1'b0;
      decAllocate <= 1'b0;
      decSource   <= '0;
    end else begin
      decValid    <= reqValid;
      decAllocate <= reqValid & (|grantSrc);
      decSource   <= reqValid ? grantSrc : '0;
    end
  end
endmodule

// File: rtl/wa_decider.sv
module wa_decider
  import wa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int LIM_W    = 7,
  parameter int LIM_LSB  = 22
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       sectorHit,
  input  logic                       pageCacheDisable,
  input  logic                       cacheDisable,
  input  logic                       cacheInhibit,
  input  logic                       fillValid,
  input  logic [ADDR_W-PAGE_LSB-1:0] fillPage,
  input  logic                       kenWrValid,
  input  logic [ADDR_W-PAGE_LSB-1:0] kenWrPage,
  input  logic                       cfgWrEn,
  input  logic [LIM_W+1:0]           cfgWrData,
  input  logic                       tlbChange,
  input  logic                       cacheInval,
  input  logic                       flushReq,
  output logic                       decValid,
  output logic                       decAllocate,
  output logic [SRC_W-1:0]           decSource
);
  waStrobes_t stb;
  waMatch_t   match;

  wa_datapath #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LIM_W(LIM_W), .LIM_LSB(LIM_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWrData(cfgWrData),
    .fillPage(fillPage), .kenWrPage(kenWrPage), .reqAddr(reqAddr), .match(match)
  );

  wa_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sectorHit(sectorHit),
    .pageCacheDisable(pageCacheDisable), .cacheDisable(cacheDisable),
    .cacheInhibit(cacheInhibit), .fillValid(fillValid), .kenWrValid(kenWrValid),
    .cfgWrEn(cfgWrEn), .tlbChange(tlbChange), .cacheInval(cacheInval),
    .flushReq(flushReq), .match(match), .stb(stb), .decValid(decValid),
    .decAllocate(decAllocate), .decSource(decSource)
  );
endmodule

// File: rtl/wa_decider_chk.sv
module wa_decider_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              sectorHit,
  input logic              pageCacheDisable,
  input logic              cacheDisable,
  input logic              cacheInhibit,
  input logic              tlbChange,
  input logic              cacheInval,
  input logic              flushReq,
  input logic              decValid,
  input logic              decAllocate,
  input logic [3:0]        decSource
);
  logic inHole, offAll;
  assign inHole = (reqAddr >= ADDR_W'(32'h000A_0000)) && (reqAddr <= ADDR_W'(32'h000F_FFFF));
  assign offAll = cacheDisable | pageCacheDisable | cacheInhibit;

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !decValid && !decAllocate);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> decValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN) !reqValid |=> !decValid);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (decSource == 4'd0) && !decAllocate);
  p_sector_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && sectorHit && !offAll && !inHole |=> decSource[1]);
  p_ken_forget_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tlbChange || cacheInval || flushReq) ##1 reqValid |=> !decSource[2]);
  p_hole_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && inHole |=> !decAllocate);
  p_disable_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && offAll |=> !decAllocate && decSource == 4'd0);
  p_or_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> decAllocate == (decSource != 4'd0));
endmodule

bind wa_decider wa_decider_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wa_decider_tb.sv
module wa_decider_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, sectorHit = 0, pageCacheDisable = 0, cacheDisable = 0, cacheInhibit = 0;
  logic [31:0] reqAddr = '0;
  logic fillValid = 0, kenWrValid = 0, cfgWrEn = 0, tlbChange = 0, cacheInval = 0, flushReq = 0;
  logic [19:0] fillPage = '0, kenWrPage = '0;
  logic [8:0] cfgWrData = '0;
  logic decValid, decAllocate;
  logic [3:0] decSource;

  always #10 clk = ~clk;

  wa_decider u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  // bench model of register state, from the requirements
  logic [8:0]  mCfg = '0;
  logic [19:0] mFill = '0, mKen = '0;
  logic        mFillV = 0, mKenV = 0;

  function automatic logic [3:0] expSrc(logic [31:0] a, logic sec, logic pcd);
    logic [3:0] s;
    logic [6:0] f;
    f = mCfg[7:1];
    s[0] = mFillV && (a[31:12] == mFill);
    s[1] = sec;
    s[2] = mKenV && mCfg[8] && (a[31:12] == mKen);
    s[3] = (f != 0) && ({22'd0, a[31:22]} < 32'(f));
    if (f >= 7'd4 && a >= 32'h00F0_0000 && a <= 32'h00FF_FFFF && !mCfg[0]) s[3] = 1'b0;
    if (cacheDisable || pcd || cacheInhibit || (a >= 32'h000A_0000 && a <= 32'h000F_FFFF)) s = 4'd0;
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReq(logic [31:0] a, logic sec, logic pcd, string tag);
    logic [3:0] e;
    e = expSrc(a, sec, pcd);
    @(negedge clk);
    reqValid = 1; reqAddr = a; sectorHit = sec; pageCacheDisable = pcd;
    @(negedge clk);
    reqValid = 0; sectorHit = 0; pageCacheDisable = 0;
    check(tag, {decValid, decAllocate, decSource}, {1'b1, |e, e});
  endtask

  task automatic cfgWrite(logic [8:0] d);
    @(negedge clk); cfgWrEn = 1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 0; mCfg = d;
  endtask

  task automatic fillEvt(logic [19:0] p);
    @(negedge clk); fillValid = 1; fillPage = p;
    @(negedge clk); fillValid = 0; mFill = p; mFillV = 1;
  endtask

  task automatic kenEvt(logic [19:0] p);
    @(negedge clk); kenWrValid = 1; kenWrPage = p;
    @(negedge clk); kenWrValid = 0; mKen = p; mKenV = 1;
  endtask

  task automatic invEvt(int which);
    @(negedge clk);
    tlbChange = (which == 0); cacheInval = (which == 1); flushReq = (which == 2);
    @(negedge clk);
    tlbChange = 0; cacheInval = 0; flushReq = 0; mKenV = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {decValid, decAllocate, decSource}, 0);
    rstN = 1;
    @(negedge clk);
    check("R2 idle", {decValid, decAllocate, decSource}, 0);
    doReq(32'h0000_1000, 0, 0, "R1 cleared state");
    doReq(32'h0000_0000, 0, 0, "R1 cleared limit");

    // R7 R8 R9 sweep over every limit value and the window bit
    for (int f = 0; f < 128; f++) begin
      for (int w = 0; w < 2; w++) begin
        cfgWrite({1'b0, 7'(f), 1'(w)});
        doReq((f == 0) ? 32'h4 : (32'(f) << 22) - 32'd4, 0, 0, "R7 below limit");
        doReq(32'(f) << 22, 0, 0, "R7 at limit");
        doReq(32'h00F8_0000, 0, 0, "R8 mid window");
        doReq(32'h00EF_FFFC, 0, 0, "R8 below window");
        doReq(32'h0100_0000, 0, 0, "R8 above window");
        doReq(32'h000A_0000, 0, 0, "R9 hole low");
        doReq(32'h000F_FFFC, 0, 0, "R9 hole high");
        doReq(32'h0009_FFFC, 0, 0, "R9 below hole");
        doReq(32'h0010_0000, 0, 0, "R9 above hole");
      end
    end

    cfgWrite(9'h000);
    // R3 fill page
    doReq(32'h1234_5678, 0, 0, "R3 before fill");
    fillEvt(20'h12345);
    doReq(32'h1234_5ABC, 0, 0, "R3 same page");
    doReq(32'h1234_6000, 0, 0, "R3 other page");
    fillEvt(20'h000A0);
    doReq(32'h000A_0010, 0, 0, "R9 hole blocks fill page");

    // R4 sector
    doReq(32'h3000_0000, 1, 0, "R4 sector hit");
    doReq(32'h000B_0000, 1, 0, "R9 hole blocks sector");

    // R5 learned page
    kenEvt(20'h40001);
    doReq(32'h4000_1000, 0, 0, "R5 detect off");
    cfgWrite(9'h100);
    doReq(32'h4000_1FF0, 0, 0, "R5 detect on");
    doReq(32'h4000_2000, 0, 0, "R5 other page");

    // R6 forgetting, each source
    for (int k = 0; k < 3; k++) begin
      kenEvt(20'h40001);
      doReq(32'h4000_1000, 0, 0, "R6 relearned");
      invEvt(k);
      doReq(32'h4000_1000, 0, 0, "R6 forgotten");
    end
    @(negedge clk); kenWrValid = 1; kenWrPage = 20'h50005; tlbChange = 1;
    @(negedge clk); kenWrValid = 0; tlbChange = 0; mKenV = 0;
    doReq(32'h5000_5000, 0, 0, "R6 invalidate beats capture");

    // R10 disables with several paths matching
    cfgWrite(9'h1FF);
    fillEvt(20'h00200);
    kenEvt(20'h00200);
    doReq(32'h0020_0000, 1, 0, "R11 all four paths");
    doReq(32'h0020_0000, 1, 1, "R10 page cache disable");
    cacheDisable = 1;
    doReq(32'h0020_0000, 1, 0, "R10 cache disable");
    cacheDisable = 0; cacheInhibit = 1;
    doReq(32'h0020_0000, 1, 0, "R10 cache inhibit");
    cacheInhibit = 0;
    doReq(32'h0020_0000, 0, 0, "R11 three paths");

    // R12 same-cycle ordering
    cfgWrite(9'h000);
    begin
      logic [3:0] e;
      e = expSrc(32'h6000_0000, 0, 0);
      @(negedge clk); reqValid = 1; reqAddr = 32'h6000_0000; fillValid = 1; fillPage = 20'h60000;
      @(negedge clk); reqValid = 0; fillValid = 0; mFill = 20'h60000; mFillV = 1;
      check("R12 fill same cycle", {decValid, decAllocate, decSource}, {1'b1, |e, e});
      e = expSrc(32'h0000_0000, 0, 0);
      @(negedge clk); reqValid = 1; reqAddr = 32'h0; cfgWrEn = 1; cfgWrData = 9'h0FE;
      @(negedge clk); reqValid = 0; cfgWrEn = 0; mCfg = 9'h0FE;
      check("R12 cfg same cycle", {decValid, decAllocate, decSource}, {1'b1, |e, e});
    end
    doReq(32'h6000_0040, 0, 0, "R12 fill seen next");
    doReq(32'h0000_0000, 0, 0, "R12 cfg seen next");
    @(negedge clk);
    check("R2 no request", {decValid, decAllocate, decSource}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule